// File: doc/BRIEF.md
# Serial NVRAM Dword Command Engine

This block carries out one 32-bit read, write or page-erase transfer at a time against a serial non-volatile memory on behalf of a host register interface. The host loads an address register and a write-data register. It then writes a command word: a go bit, plus optional burst-open (first), burst-close (last), write and erase bits, and a done-clear bit. The engine keeps an internal linear byte address. A command that carries the first flag loads that address from the address register. Every later command continues from where the previous one stopped, so a run of dwords needs the address written only once.

A mode input selects how linear offsets map onto the device. In the small EEPROM mode and in the plain flash mode the physical address equals the linear offset. In buffered-flash mode each page holds 264 bytes but sits on a 512-byte physical stride, so the engine remaps every offset before the access. Data crosses the host interface with its byte order reversed relative to device byte addresses. Completion is reported by a sticky done flag, which the host clears. The serial device is a behavioural memory with a fixed access latency, and its contents come out of reset with a computed pattern so that byte order can be seen at the ports.

Top module: `nvm_dword_engine`

## Requirements
- R1: After reset, done, busy, err and burst_open are 0 and cur_addr is 0. The device byte at physical address p holds p[7:0] XOR 8'hA5.
- R2: An accepted command sets busy in the following cycle. busy stays 1 and done stays 0 for exactly LAT cycles, after which busy is 0 and done is 1. On a read (write bit 0), rdata then holds the device byte at physical address P in bits 31:24, P+1 in bits 23:16, P+2 in bits 15:8 and P+3 in bits 7:0.
- R3: A command with the write bit set and the erase bit clear stores wdata_in[31:24] at physical byte P, [23:16] at P+1, [15:8] at P+2 and [7:0] at P+3.
- R4: A command with the first flag takes its linear address from the last value written through addr_wdata. A command without the first flag uses cur_addr. After every completed command, cur_addr equals the linear address of that command plus 4, modulo 2^AW.
- R5: With mode_sel = 2'b10 (buffered flash), the physical address is (L / 264) * 512 + (L % 264) for linear address L.
- R6: With mode_sel = 2'b00 (EEPROM) or 2'b01 (flash), the physical address equals the linear address.
- R7: A command with both the write and erase bits set sets every byte of the physical page holding P to 8'hFF and leaves all other bytes unchanged. The page is 4 bytes in mode 2'b00, 256 bytes in mode 2'b01 and 512 bytes in mode 2'b10. An erase bit with the write bit clear acts as a plain read.
- R8: A go command written while busy is 1 is ignored: the running command finishes with its own result and cur_addr advances only once. The same event sets err, which stays 1 until reset.
- R9: Once done is set it holds until the host writes the command word with done-clear set, or until a new command is accepted. A done-clear write while idle makes done 0 in the next cycle.
- R10: burst_open becomes 1 when a command with the first flag is accepted. It returns to 0 when a command with the last flag completes, and it stays 1 across intermediate commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Device mode: 00 EEPROM, 01 flash, 10 buffered flash |
| addr_we | input | 1 | Strobe to load the address register |
| addr_wdata | input | AW | Linear byte address to load |
| wdata_we | input | 1 | Strobe to load the write-data register |
| wdata_in | input | 32 | Write data in host byte order |
| cmd_we | input | 1 | Strobe for a command word write |
| cmd_go | input | 1 | Command word: start a transfer |
| cmd_first | input | 1 | Command word: load the address register and open a burst |
| cmd_last | input | 1 | Command word: close the burst on completion |
| cmd_wr | input | 1 | Command word: write (or erase when combined with cmd_erase) |
| cmd_erase | input | 1 | Command word: erase the page |
| cmd_done_clr | input | 1 | Command word: clear the done flag |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | Sticky completion flag |
| err | output | 1 | Sticky flag for a go command rejected while busy |
| burst_open | output | 1 | A burst opened by the first flag is still open |
| cur_addr | output | AW | Internal linear byte address |
| rdata | output | 32 | Read data in host byte order |

## Verification
The bench runs a burst that starts at linear offset 260 in buffered mode and crosses into the next page. A translation that fails to skip the 248-byte gap reads byte 264 instead of physical byte 512 and returns the wrong pattern. Erases are aimed at an address in the middle of a page in every mode, with reads placed just inside and just outside the page. An erase that used the wrong page size, or worked from the linear address, wipes a neighbour or leaves page bytes intact. A second go written during a busy period checks that the running command keeps its result and that cur_addr advances only once. Random single dwords in all three modes are checked against a byte-level model, which exposes a missing or doubled byte swap through the non-symmetric reset pattern.

// File: rtl/nvm_eng_pkg.sv
package nvm_eng_pkg;

  typedef enum logic [1:0] {
    MODE_EEPROM   = 2'b00,
    MODE_FLASH    = 2'b01,
    MODE_BUFFERED = 2'b10,
    MODE_SPARE    = 2'b11
  } nvm_mode_e;

  localparam int unsigned BUF_PAGE_BYTES = 264;
  localparam int unsigned BUF_SHIFT      = 9;
  localparam int unsigned FLASH_SHIFT    = 8;
  localparam int unsigned EE_SHIFT       = 2;
  localparam logic [7:0]  SEED_XOR       = 8'hA5;

  // reverse byte order between host and device views
  function automatic logic [31:0] swap32(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  // log2 of the physical page stride for a mode
  function automatic logic [3:0] page_shift(input nvm_mode_e m);
    case (m)
      MODE_EEPROM:   return 4'(EE_SHIFT);
      MODE_BUFFERED: return 4'(BUF_SHIFT);
      default:       return 4'(FLASH_SHIFT);
    endcase
  endfunction

  // linear offset -> physical address for 264-byte pages on 512-byte stride
  function automatic logic [31:0] buf_remap(input logic [31:0] off);
    logic [31:0] pg;
    logic [31:0] rem;
    pg  = off / BUF_PAGE_BYTES;
    rem = off % BUF_PAGE_BYTES;
    return (pg << BUF_SHIFT) + rem;
  endfunction

  // reset pattern of device word k, byte at lowest address in bits 7:0
  function automatic logic [31:0] seed_word(input int unsigned k);
    logic [31:0] w;
    w = '0;
    for (int j = 0; j < 4; j++) begin
      w[8*j +: 8] = 8'(4 * k + j) ^ SEED_XOR;
    end
    return w;
  endfunction

endpackage

// File: rtl/nvm_addr_xlate.sv
module nvm_addr_xlate
  import nvm_eng_pkg::*;
#(
  parameter int unsigned AW = 11
) (
  input  nvm_mode_e         mode,
  input  logic [AW-1:0]     lin_addr,
  output logic [AW-1:0]     phys_addr,
  output logic [3:0]        pg_shift
);

  logic [31:0] remapped;

  always_comb begin
    remapped = buf_remap(32'(lin_addr));
    if (mode == MODE_BUFFERED) begin
      phys_addr = remapped[AW-1:0];
    end else begin
      phys_addr = lin_addr;
    end
    pg_shift = page_shift(mode);
  end

endmodule

// File: rtl/nvm_behav_mem.sv
module nvm_behav_mem
  import nvm_eng_pkg::*;
#(
  parameter int unsigned AW = 11,
  localparam int unsigned WA    = AW - 2,
  localparam int unsigned WORDS = 1 << WA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_en,
  input  logic          acc_wr,
  input  logic          acc_erase,
  input  logic [WA-1:0] acc_word,
  input  logic [3:0]    pg_shift,
  input  logic [31:0]   acc_wdata,
  output logic [31:0]   rd_word
);

  logic [31:0] words [WORDS];
  logic [3:0]  grp_shift;

  // word-granular group size: page shift minus the 2 byte bits
  assign grp_shift = pg_shift - 4'd2;

  for (genvar k = 0; k < WORDS; k++) begin : g_word
    logic [31:0] word_q;
    logic        in_page;
    logic        is_target;

    assign in_page   = ((WA'(k) >> grp_shift) == (acc_word >> grp_shift));
    assign is_target = (acc_word == WA'(k));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        word_q <= seed_word(k);
      end else if (acc_en && acc_erase && in_page) begin
        word_q <= 32'hFFFF_FFFF;
      end else if (acc_en && acc_wr && is_target) begin
        word_q <= acc_wdata;
      end
    end

    assign words[k] = word_q;
  end

  assign rd_word = words[acc_word];

endmodule

// File: rtl/nvm_cmd_ctrl.sv
module nvm_cmd_ctrl #(
  parameter int unsigned AW  = 11,
  parameter int unsigned LAT = 6,
  localparam int unsigned CW = $clog2(LAT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_we,
  input  logic          cmd_go,
  input  logic          cmd_first,
  input  logic          cmd_last,
  input  logic          cmd_wr,
  input  logic          cmd_erase,
  input  logic          cmd_done_clr,
  input  logic [AW-1:0] addr_reg,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          burst_open,
  output logic [AW-1:0] lin_addr,
  output logic          op_wr,
  output logic          op_erase,
  output logic          op_last,
  output logic          accept_evt,
  output logic          finish_evt
);

  logic [CW-1:0] cnt_q;
  logic          reject_evt;

  assign accept_evt = cmd_we && cmd_go && !busy;
  assign reject_evt = cmd_we && cmd_go && busy;
  assign finish_evt = busy && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      err        <= 1'b0;
      burst_open <= 1'b0;
      lin_addr   <= '0;
      op_wr      <= 1'b0;
      op_erase   <= 1'b0;
      op_last    <= 1'b0;
      cnt_q      <= '0;
    end else begin
      if (accept_evt) begin
        busy     <= 1'b1;
        done     <= 1'b0;
        cnt_q    <= CW'(LAT - 1);
        op_wr    <= cmd_wr;
        op_erase <= cmd_erase;
        op_last  <= cmd_last;
        if (cmd_first) begin
          lin_addr   <= addr_reg;
          burst_open <= 1'b1;
        end
      end else if (finish_evt) begin
        busy     <= 1'b0;
        done     <= 1'b1;
        lin_addr <= lin_addr + AW'(4);
        if (op_last) begin
          burst_open <= 1'b0;
        end
      end else begin
        if (busy) begin
          cnt_q <= cnt_q - CW'(1);
        end
        if (cmd_we && cmd_done_clr) begin
          done <= 1'b0;
        end
      end
      if (reject_evt) begin
        err <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/nvm_dword_engine.sv
module nvm_dword_engine
  import nvm_eng_pkg::*;
#(
  parameter int unsigned AW  = 11,
  parameter int unsigned LAT = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_sel,
  input  logic          addr_we,
  input  logic [AW-1:0] addr_wdata,
  input  logic          wdata_we,
  input  logic [31:0]   wdata_in,
  input  logic          cmd_we,
  input  logic          cmd_go,
  input  logic          cmd_first,
  input  logic          cmd_last,
  input  logic          cmd_wr,
  input  logic          cmd_erase,
  input  logic          cmd_done_clr,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          burst_open,
  output logic [AW-1:0] cur_addr,
  output logic [31:0]   rdata
);

  localparam int unsigned WA = AW - 2;

  logic [AW-1:0] addr_reg;
  logic [31:0]   wdata_reg;
  logic [31:0]   rdata_q;
  logic [AW-1:0] lin_addr;
  logic [AW-1:0] phys_addr;
  logic [3:0]    pg_shift;
  logic          op_wr;
  logic          op_erase;
  logic          op_last;
  logic          accept_evt;
  logic          finish_evt;
  logic [31:0]   mem_rd;
  logic          mem_wr;
  logic          mem_erase;
  nvm_mode_e     mode;

  assign mode = nvm_mode_e'(mode_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_reg  <= '0;
      wdata_reg <= '0;
    end else begin
      if (addr_we)  addr_reg  <= addr_wdata;
      if (wdata_we) wdata_reg <= wdata_in;
    end
  end

  nvm_cmd_ctrl #(.AW(AW), .LAT(LAT)) ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_we       (cmd_we),
    .cmd_go       (cmd_go),
    .cmd_first    (cmd_first),
    .cmd_last     (cmd_last),
    .cmd_wr       (cmd_wr),
    .cmd_erase    (cmd_erase),
    .cmd_done_clr (cmd_done_clr),
    .addr_reg     (addr_reg),
    .busy         (busy),
    .done         (done),
    .err          (err),
    .burst_open   (burst_open),
    .lin_addr     (lin_addr),
    .op_wr        (op_wr),
    .op_erase     (op_erase),
    .op_last      (op_last),
    .accept_evt   (accept_evt),
    .finish_evt   (finish_evt)
  );

  nvm_addr_xlate #(.AW(AW)) xlate_i (
    .mode      (mode),
    .lin_addr  (lin_addr),
    .phys_addr (phys_addr),
    .pg_shift  (pg_shift)
  );

  assign mem_wr    = op_wr && !op_erase;
  assign mem_erase = op_wr && op_erase;

  nvm_behav_mem #(.AW(AW)) mem_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_en    (finish_evt),
    .acc_wr    (mem_wr),
    .acc_erase (mem_erase),
    .acc_word  (phys_addr[AW-1:2]),
    .pg_shift  (pg_shift),
    .acc_wdata (swap32(wdata_reg)),
    .rd_word   (mem_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (finish_evt && !op_wr) begin
      rdata_q <= swap32(mem_rd);
    end
  end

  assign rdata    = rdata_q;
  assign cur_addr = lin_addr;

endmodule

// File: rtl/nvm_dword_engine_chk.sv
module nvm_dword_engine_chk #(
  parameter int unsigned AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_we,
  input logic          cmd_go,
  input logic          cmd_first,
  input logic          cmd_done_clr,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic          burst_open,
  input logic [AW-1:0] cur_addr,
  input logic          accept_evt,
  input logic          finish_evt,
  input logic          op_last
);

  assert_busy_no_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

  assert_done_on_finish_R2: assert property (@(posedge clk) disable iff (!rst_n)
    finish_evt |=> (done && !busy));

  assert_addr_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    finish_evt |=> (cur_addr == $past(cur_addr) + AW'(4)));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  assert_reject_sets_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_go && busy) |=> err);

  assert_reject_keeps_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_go && busy && !finish_evt) |=> $stable(cur_addr));

  assert_done_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_done_clr && !cmd_go && !busy) |=> !done);

  assert_burst_opens_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_evt && cmd_first) |=> burst_open);

  assert_burst_closes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (finish_evt && op_last) |=> !burst_open);

endmodule

bind nvm_dword_engine nvm_dword_engine_chk #(.AW(AW)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_we       (cmd_we),
  .cmd_go       (cmd_go),
  .cmd_first    (cmd_first),
  .cmd_done_clr (cmd_done_clr),
  .busy         (busy),
  .done         (done),
  .err          (err),
  .burst_open   (burst_open),
  .cur_addr     (cur_addr),
  .accept_evt   (accept_evt),
  .finish_evt   (finish_evt),
  .op_last      (op_last)
);

// File: tb/nvm_dword_engine_tb.sv
module nvm_dword_engine_tb_top;

  localparam int AW   = 11;
  localparam int LAT  = 6;
  localparam int SIZE = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    mode_sel;
  logic          addr_we;
  logic [AW-1:0] addr_wdata;
  logic          wdata_we;
  logic [31:0]   wdata_in;
  logic          cmd_we, cmd_go, cmd_first, cmd_last, cmd_wr, cmd_erase, cmd_done_clr;
  logic          busy, done, err, burst_open;
  logic [AW-1:0] cur_addr;
  logic [31:0]   rdata;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [7:0] mdl [SIZE];
  int addr_shadow;
  int exp_lin;
  logic [31:0] wdata_shadow;

  always #4 clk = ~clk;

  nvm_dword_engine #(.AW(AW), .LAT(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .addr_we(addr_we), .addr_wdata(addr_wdata),
    .wdata_we(wdata_we), .wdata_in(wdata_in),
    .cmd_we(cmd_we), .cmd_go(cmd_go), .cmd_first(cmd_first), .cmd_last(cmd_last),
    .cmd_wr(cmd_wr), .cmd_erase(cmd_erase), .cmd_done_clr(cmd_done_clr),
    .busy(busy), .done(done), .err(err), .burst_open(burst_open),
    .cur_addr(cur_addr), .rdata(rdata)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int p = 0; p < SIZE; p++) mdl[p] = 8'(p) ^ 8'hA5;
    addr_shadow  = 0;
    exp_lin      = 0;
    wdata_shadow = '0;
  endtask

  // buffered pages of 264 bytes laid out every 512 bytes
  function automatic int phys_of(input int lin, input int mode);
    int pg, rem;
    if (mode != 2) return lin % SIZE;
    pg = 0;
    rem = lin;
    while (rem >= 264) begin
      rem -= 264;
      pg++;
    end
    return (pg * 512 + rem) % SIZE;
  endfunction

  function automatic logic [31:0] host_word(input int p);
    return {mdl[p], mdl[p+1], mdl[p+2], mdl[p+3]};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
  endtask

  task automatic set_addr(input int a);
    addr_we = 1'b1;
    addr_wdata = AW'(a);
    @(negedge clk);
    addr_we = 1'b0;
    addr_shadow = a;
  endtask

  task automatic set_wdata(input logic [31:0] w);
    wdata_we = 1'b1;
    wdata_in = w;
    @(negedge clk);
    wdata_we = 1'b0;
    wdata_shadow = w;
  endtask

  task automatic release_cmd();
    cmd_we = 0; cmd_go = 0; cmd_first = 0; cmd_last = 0;
    cmd_wr = 0; cmd_erase = 0; cmd_done_clr = 0;
  endtask

  // issue one command; poke = write a second go while busy
  task automatic run_cmd(input bit first, input bit last, input bit wr,
                         input bit erase, input bit poke, input string req);
    int lin, p, base, span, waited;
    logic [31:0] exp_rd;
    cmd_we = 1; cmd_go = 1; cmd_first = first; cmd_last = last;
    cmd_wr = wr; cmd_erase = erase; cmd_done_clr = 1;
    @(negedge clk);
    check(busy === 1'b1 && done === 1'b0, "R2", "busy after accept", {30'b0, busy, done}, 32'h2);
    waited = 1;
    if (poke) begin
      cmd_we = 1; cmd_go = 1; cmd_first = 1; cmd_last = 0; cmd_wr = 1; cmd_erase = 1;
      @(negedge clk);
      waited = 2;
    end
    release_cmd();
    repeat (LAT - waited) @(negedge clk);
    check(busy === 1'b1 && done === 1'b0, "R2", "still busy at LAT-1", {30'b0, busy, done}, 32'h2);
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b1, "R2", "done after LAT", {30'b0, busy, done}, 32'h1);
    lin = first ? addr_shadow : exp_lin;
    p = phys_of(lin, int'(mode_sel));
    if (wr && erase) begin
      span = (mode_sel == 2'b00) ? 4 : (mode_sel == 2'b10) ? 512 : 256;
      base = p - (p % span);
      for (int i = 0; i < span; i++) mdl[base + i] = 8'hFF;
    end else if (wr) begin
      mdl[p]   = wdata_shadow[31:24];
      mdl[p+1] = wdata_shadow[23:16];
      mdl[p+2] = wdata_shadow[15:8];
      mdl[p+3] = wdata_shadow[7:0];
    end else begin
      exp_rd = host_word(p);
      check(rdata === exp_rd, req, "read data", rdata, exp_rd);
    end
    exp_lin = (lin + 4) % SIZE;
    check(cur_addr === AW'(exp_lin), "R4", "cur_addr advance", 32'(cur_addr), 32'(exp_lin));
  endtask

  task automatic read_at(input int a, input string req);
    set_addr(a);
    run_cmd(1, 1, 0, 0, 0, req);
  endtask

  task automatic write_at(input int a, input logic [31:0] w, input string req);
    set_wdata(w);
    set_addr(a);
    run_cmd(1, 1, 1, 0, 0, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    mode_sel = 2'b01;
    addr_we = 0; addr_wdata = '0; wdata_we = 0; wdata_in = '0;
    release_cmd();
    model_reset();
    do_reset();

    // R1 reset state
    check({done, busy, err, burst_open} === 4'b0, "R1", "flags after reset",
          {28'b0, done, busy, err, burst_open}, 32'h0);
    check(cur_addr === '0, "R1", "cur_addr after reset", 32'(cur_addr), 32'h0);

    // R2 R6 flash mode read shows byte order of the seed pattern
    mode_sel = 2'b01;
    read_at(32'h40, "R2");
    // R3 write then read back, R6 no translation
    write_at(32'h80, 32'h1122_3344, "R3");
    read_at(32'h80, "R3");
    mode_sel = 2'b00;
    read_at(32'h80, "R6");

    // R4 R10 burst of three dwords in flash mode
    mode_sel = 2'b01;
    set_addr(32'h100);
    run_cmd(1, 0, 0, 0, 0, "R4");
    check(burst_open === 1'b1, "R10", "open after first", {31'b0, burst_open}, 32'h1);
    set_addr(32'h400);  // must not be used without first
    run_cmd(0, 0, 0, 0, 0, "R4");
    check(burst_open === 1'b1, "R10", "open mid burst", {31'b0, burst_open}, 32'h1);
    run_cmd(0, 1, 0, 0, 0, "R4");
    check(burst_open === 1'b0, "R10", "closed after last", {31'b0, burst_open}, 32'h0);

    // R5 buffered burst crossing from page 0 into page 1
    mode_sel = 2'b10;
    set_addr(260);
    run_cmd(1, 0, 0, 0, 0, "R5");
    run_cmd(0, 1, 0, 0, 0, "R5");
    read_at(1055 & ~3, "R5");
    set_wdata(32'hDEAD_BEEF);
    set_addr(528);
    run_cmd(1, 1, 1, 0, 0, "R5");
    mode_sel = 2'b01;
    read_at(1024 + 264, "R5");

    // R7 erase in each mode, then probe inside and outside the page
    mode_sel = 2'b01;
    set_addr(32'h1C4);
    run_cmd(1, 1, 1, 1, 0, "R7");
    read_at(32'h100, "R7");
    read_at(32'h1FC, "R7");
    read_at(32'h200, "R7");
    read_at(32'h0FC, "R7");
    mode_sel = 2'b00;
    set_addr(32'h288);
    run_cmd(1, 1, 1, 1, 0, "R7");
    read_at(32'h284, "R7");
    read_at(32'h288, "R7");
    read_at(32'h28C, "R7");
    mode_sel = 2'b10;
    set_addr(264 * 2 + 8);
    run_cmd(1, 1, 1, 1, 0, "R7");
    mode_sel = 2'b01;
    read_at(1024, "R7");
    read_at(1020, "R7");
    read_at(1536, "R7");
    // R7 erase bit without write bit acts as read
    set_addr(32'h300);
    run_cmd(1, 1, 0, 1, 0, "R7");
    read_at(32'h300, "R7");

    // R8 go while busy is ignored and sets err
    check(err === 1'b0, "R8", "err clear before reject", {31'b0, err}, 32'h0);
    set_addr(32'h500);
    run_cmd(1, 1, 0, 0, 1, "R8");
    check(err === 1'b1, "R8", "err after reject", {31'b0, err}, 32'h1);
    read_at(32'h500, "R8");
    check(err === 1'b1, "R8", "err sticky", {31'b0, err}, 32'h1);

    // R9 done holds then clears on request
    repeat (5) @(negedge clk);
    check(done === 1'b1, "R9", "done held", {31'b0, done}, 32'h1);
    cmd_we = 1; cmd_done_clr = 1;
    @(negedge clk);
    release_cmd();
    check(done === 1'b0, "R9", "done cleared", {31'b0, done}, 32'h0);

    // random single dwords against the byte model
    for (int it = 0; it < 80; it++) begin
      int m, a, op;
      m = $urandom % 3;
      mode_sel = 2'(m);
      a = (m == 2) ? (($urandom % 1056) & ~3) : (($urandom % SIZE) & ~3);
      op = $urandom % 20;
      if (op < 10) begin
        read_at(a, "R2");
      end else if (op < 18) begin
        write_at(a, $urandom, "R3");
      end else begin
        set_addr(a);
        run_cmd(1, 1, 1, 1, 0, "R7");
      end
    end
    mode_sel = 2'b01;
    for (int a = 0; a < SIZE; a += 64) read_at(a, "R3");

    // R1 R8 reset clears the sticky error and restores contents
    do_reset();
    check(err === 1'b0 && done === 1'b0, "R1", "flags after second reset",
          {30'b0, err, done}, 32'h0);
    read_at(32'h1C4, "R1");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule